// File: doc/BRIEF.md
# Stream-to-Memory DMA Engine

This block is a single-channel engine that moves one packet at a time from an AXI4-Stream input into memory through an AXI4 write master. It has no descriptors. Software sets it up through a small word-indexed register port. It sets the run bit, writes the destination address, and then writes the receive-buffer capacity. The capacity write arms the channel. The packet ends on the stream beat that carries TLAST, so the incoming data decides how many bytes are moved. The capacity written by software is only an upper bound.

When the packet is done, the length register reads back the number of bytes actually received and the completion flag rises. If the packet is larger than the buffer, the engine writes only up to the end of the buffer. It then discards the rest of the packet up to TLAST, raises the error flag and stops. A failed write response also raises the error flag and stops the channel. A single level interrupt line reflects each flag gated by its enable. Every stream beat becomes one single-beat INCR write on the memory side, and only one write is in flight at a time.

Top module: `s2m_dma`

## Requirements
- R1: After reset, control (select 0) reads 0, status (select 1) reads 0x3 (bit0 halted, bit1 idle, bit2 done, bit3 error), length (select 3) reads 0, irq is low and s_tready is low.
- R2: Writing control with bit0 (run) set clears the halted status bit. s_tready stays low until the channel has been armed.
- R3: A non-zero write to the length register (select 3) arms a transfer only while the channel is running and idle. A zero write, or any write while halted, changes nothing: the length readback is unchanged, the idle bit stays set and s_tready stays low.
- R4: The received bytes are stored in memory starting at the destination address (select 2), which must be a multiple of the bus width in bytes. Beat k goes to address + k*4 as a single-beat INCR write (awlen 0, awsize 2 for a 32-bit bus).
- R5: On the TLAST beat, TKEEP (contiguous from bit 0, never all zero) becomes the write strobe. Memory bytes past the packet end keep their old value.
- R6: When the final write response returns OKAY, status bit2 (done) is set, the idle bit returns, and the length register reads the number of bytes received.
- R7: irq equals (done AND control bit1) OR (error AND control bit2).
- R8: If a packet exceeds the buffer capacity, only the first capacity bytes are written and the rest is accepted and discarded up to TLAST. The error flag (bit3) is then set, run is cleared, halted is set, and length reads the capacity.
- R9: A write response with bit1 set (SLVERR or DECERR) stops further writes. The rest of the packet is drained, then the error flag and halted are set.
- R10: Writing 1 to status bit2 or bit3 clears that flag. Writing 0 leaves it unchanged.
- R11: At most one write address is outstanding. A new address is issued only after the previous write response has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select: 0 control, 1 status, 2 address, 3 length |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 2 | Read select, same encoding |
| reg_rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt |
| s_tdata | input | DATA_W | Stream data |
| s_tkeep | input | DATA_W/8 | Stream byte qualifiers |
| s_tlast | input | 1 | Last beat of packet |
| s_tvalid | input | 1 | Stream valid |
| s_tready | output | 1 | Stream ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Burst length, always 0 |
| m_awsize | output | 3 | Beat size |
| m_awburst | output | 2 | Burst type, INCR |
| m_awvalid | output | 1 | Address valid |
| m_awready | input | 1 | Address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write strobes |
| m_wlast | output | 1 | Last write beat, always 1 |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Response valid |
| m_bready | output | 1 | Response ready |

## Verification
Random packets that fit the buffer vary the byte count, the destination and the stream gaps. They tell apart correct address stepping from off-by-one offsets, and show that the last-beat strobes trim the packet end instead of spilling into the next bytes. Packets of exactly the buffer size separate the "fits" boundary from overflow. Two overflow cases exercise the two trimming paths: one where the buffer ends inside a beat, and one where it ends on a beat boundary so the next beat finds no room at all. An injected slave error separates response-error halting from size overflow. Directed writes of zero length and writes while halted show that arming is correctly gated.

// File: rtl/s2m_dma_pkg.sv
// Shared types and constants of the stream-to-memory DMA.
// Assumes a 32-bit register port with a 2-bit word select.
package s2m_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAKE,
        ST_WRITE,
        ST_RESP,
        ST_DRAIN
    } eng_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_STAT = 2'd1;
    localparam logic [1:0] SEL_DST  = 2'd2;
    localparam logic [1:0] SEL_LEN  = 2'd3;

    localparam int CTRL_RUN    = 0;
    localparam int CTRL_DONEIE = 1;
    localparam int CTRL_ERRIE  = 2;

    localparam int STAT_HALT = 0;
    localparam int STAT_IDLE = 1;
    localparam int STAT_DONE = 2;
    localparam int STAT_ERR  = 3;

    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/s2m_dma_regs.sv
// Register bank of the stream-to-memory DMA: control, status flags,
// destination address and buffer length. Produces the arm pulse to the
// engine and the level interrupt. Assumes the engine reports busy from
// the cycle after arm until the cycle it raises done or error.
module s2m_dma_regs
    import s2m_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              busy,
    input  logic              done_ev,
    input  logic              err_ev,
    input  logic [LEN_W-1:0]  final_cnt,
    output logic              arm,
    output logic [LEN_W-1:0]  arm_len,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              halted,
    output logic              irq
);

    logic              run_q, done_ie_q, err_ie_q;
    logic              halted_q, done_f_q, err_f_q;
    logic [ADDR_W-1:0] dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              ctrl_wr, stat_wr;

    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign stat_wr = wr_en && (wr_sel == SEL_STAT);

    // Arm only on a non-zero capacity while running and idle
    assign arm = wr_en && (wr_sel == SEL_LEN) && (wr_data[LEN_W-1:0] != '0)
                 && run_q && !halted_q && !busy;
    assign arm_len  = wr_data[LEN_W-1:0];
    assign dst_addr = dst_q;
    assign halted   = halted_q;

    // Level interrupt from the enabled flags
    assign irq = (done_f_q && done_ie_q) || (err_f_q && err_ie_q);

    // Control bits; an error clears run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            done_ie_q <= 1'b0;
            err_ie_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q     <= wr_data[CTRL_RUN];
                done_ie_q <= wr_data[CTRL_DONEIE];
                err_ie_q  <= wr_data[CTRL_ERRIE];
            end
            if (err_ev) begin
                run_q <= 1'b0;
            end
        end
    end

    // Halted state: set by error or by a stopped idle channel, cleared by run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halted_q <= 1'b1;
        end else if (err_ev) begin
            halted_q <= 1'b1;
        end else if (ctrl_wr && wr_data[CTRL_RUN]) begin
            halted_q <= 1'b0;
        end else if (!run_q && !busy) begin
            halted_q <= 1'b1;
        end
    end

    // Sticky flags with write-one-to-clear; a new event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_f_q <= 1'b0;
            err_f_q  <= 1'b0;
        end else begin
            done_f_q <= (done_f_q && !(stat_wr && wr_data[STAT_DONE])) || done_ev;
            err_f_q  <= (err_f_q  && !(stat_wr && wr_data[STAT_ERR]))  || err_ev;
        end
    end

    // Destination address and length (capacity, then received count)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q <= '0;
            len_q <= '0;
        end else begin
            if (wr_en && (wr_sel == SEL_DST)) begin
                dst_q <= wr_data[ADDR_W-1:0];
            end
            if (arm) begin
                len_q <= arm_len;
            end else if (done_ev || err_ev) begin
                len_q <= final_cnt;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL: begin
                rd_data[CTRL_RUN]    = run_q;
                rd_data[CTRL_DONEIE] = done_ie_q;
                rd_data[CTRL_ERRIE]  = err_ie_q;
            end
            SEL_STAT: begin
                rd_data[STAT_HALT] = halted_q;
                rd_data[STAT_IDLE] = !busy;
                rd_data[STAT_DONE] = done_f_q;
                rd_data[STAT_ERR]  = err_f_q;
            end
            SEL_DST: rd_data[ADDR_W-1:0] = dst_q;
            default: rd_data[LEN_W-1:0]  = len_q;
        endcase
    end

endmodule

// File: rtl/s2m_dma_strb.sv
// Per-beat byte qualifier: builds the write strobe from TKEEP (last beat
// only) and the room left in the buffer, counts the bytes written and
// flags a beat that holds more bytes than the buffer can take.
// Assumes TKEEP is contiguous from bit 0.
module s2m_dma_strb #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int CW    = $clog2(BYTES) + 1
) (
    input  logic [BYTES-1:0] keep,
    input  logic             last,
    input  logic [LEN_W-1:0] room,
    output logic [BYTES-1:0] strb,
    output logic [CW-1:0]    wr_bytes,
    output logic             over
);

    logic [BYTES-1:0] valid_b;
    logic [CW-1:0]    beat_bytes;

    // One lane per byte: valid in the beat, and inside the buffer
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign valid_b[g] = last ? keep[g] : 1'b1;
        assign strb[g]    = valid_b[g] && (room > LEN_W'(g));
    end

    // Byte counts of the beat and of the part that is written
    always_comb begin
        beat_bytes = '0;
        wr_bytes   = '0;
        for (int i = 0; i < BYTES; i++) begin
            beat_bytes = beat_bytes + CW'(valid_b[i]);
            wr_bytes   = wr_bytes + CW'(strb[i]);
        end
    end

    assign over = LEN_W'(beat_bytes) > room;

endmodule

// File: rtl/s2m_dma_engine.sv
// Transfer engine: takes stream beats one at a time and issues one
// single-beat write per beat, waiting for each response. It trims at
// the buffer end, drains the rest of an oversized or failed packet, and
// reports done or error in the cycle it returns to idle.
// Assumes an aligned destination address.
module s2m_dma_engine
    import s2m_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int CW    = $clog2(BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [LEN_W-1:0]  arm_len,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [BYTES-1:0]  s_tkeep,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BYTES-1:0]  m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic              busy,
    output logic              done_ev,
    output logic              err_ev,
    output logic [LEN_W-1:0]  count
);

    eng_state_t        state;
    logic [ADDR_W-1:0] base_q, awaddr_q;
    logic [LEN_W-1:0]  cap_q, cnt_q, room;
    logic [DATA_W-1:0] data_q;
    logic [BYTES-1:0]  strb_q, beat_strb;
    logic              last_q, over_q, aw_done, w_done;
    logic [CW-1:0]     beat_wr;
    logic              beat_over, aw_hs, w_hs, bad_resp;

    assign room     = cap_q - cnt_q;
    assign aw_hs    = m_awvalid && m_awready;
    assign w_hs     = m_wvalid && m_wready;
    assign bad_resp = m_bresp != 2'b00;

    s2m_dma_strb #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_strb (
        .keep     (s_tkeep),
        .last     (s_tlast),
        .room     (room),
        .strb     (beat_strb),
        .wr_bytes (beat_wr),
        .over     (beat_over)
    );

    assign s_tready  = (state == ST_TAKE) || (state == ST_DRAIN);
    assign m_awvalid = (state == ST_WRITE) && !aw_done;
    assign m_wvalid  = (state == ST_WRITE) && !w_done;
    assign m_bready  = (state == ST_RESP);
    assign m_awaddr  = awaddr_q;
    assign m_wdata   = data_q;
    assign m_wstrb   = strb_q;
    assign busy      = (state != ST_IDLE);
    assign count     = cnt_q;

    // Completion and error pulses, aligned with the return to idle
    assign done_ev = (state == ST_RESP) && m_bvalid && !bad_resp && !over_q && last_q;
    assign err_ev  = ((state == ST_RESP) && m_bvalid && (bad_resp || over_q) && last_q)
                   || ((state == ST_TAKE) && s_tvalid && (room == '0) && s_tlast)
                   || ((state == ST_DRAIN) && s_tvalid && s_tlast);

    // Transfer state machine and beat capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base_q   <= '0;
            awaddr_q <= '0;
            cap_q    <= '0;
            cnt_q    <= '0;
            data_q   <= '0;
            strb_q   <= '0;
            last_q   <= 1'b0;
            over_q   <= 1'b0;
            aw_done  <= 1'b0;
            w_done   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (arm) begin
                        base_q <= arm_addr;
                        cap_q  <= arm_len;
                        cnt_q  <= '0;
                        state  <= ST_TAKE;
                    end
                end
                ST_TAKE: begin
                    if (s_tvalid) begin
                        if (room == '0) begin
                            state <= s_tlast ? ST_IDLE : ST_DRAIN;
                        end else begin
                            awaddr_q <= base_q + ADDR_W'(cnt_q);
                            data_q   <= s_tdata;
                            strb_q   <= beat_strb;
                            last_q   <= s_tlast;
                            over_q   <= beat_over;
                            cnt_q    <= cnt_q + LEN_W'(beat_wr);
                            aw_done  <= 1'b0;
                            w_done   <= 1'b0;
                            state    <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (aw_hs) aw_done <= 1'b1;
                    if (w_hs)  w_done  <= 1'b1;
                    if ((aw_done || aw_hs) && (w_done || w_hs)) begin
                        state <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (m_bvalid) begin
                        if (bad_resp || over_q) begin
                            state <= last_q ? ST_IDLE : ST_DRAIN;
                        end else begin
                            state <= last_q ? ST_IDLE : ST_TAKE;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (s_tvalid && s_tlast) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/s2m_dma.sv
// Top of the stream-to-memory DMA: joins the register bank and the
// transfer engine and fixes the burst attributes to single-beat INCR.
// Assumes DATA_W is a power-of-two number of bytes and ADDR_W >= LEN_W.
module s2m_dma
    import s2m_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int BYTES = DATA_W / 8,
    localparam int SIZE  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [31:0]       reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [31:0]       reg_rd_data,
    output logic              irq,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [BYTES-1:0]  s_tkeep,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BYTES-1:0]  m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready
);

    logic              arm, eng_busy, done_ev, err_ev, sts_halted;
    logic [LEN_W-1:0]  arm_len, final_cnt;
    logic [ADDR_W-1:0] dst_addr;

    assign m_awlen   = 8'd0;
    assign m_awsize  = 3'(SIZE);
    assign m_awburst = BURST_INCR;
    assign m_wlast   = 1'b1;

    s2m_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .rd_sel    (reg_rd_sel),
        .rd_data   (reg_rd_data),
        .busy      (eng_busy),
        .done_ev   (done_ev),
        .err_ev    (err_ev),
        .final_cnt (final_cnt),
        .arm       (arm),
        .arm_len   (arm_len),
        .dst_addr  (dst_addr),
        .halted    (sts_halted),
        .irq       (irq)
    );

    s2m_dma_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_len   (arm_len),
        .arm_addr  (dst_addr),
        .s_tdata   (s_tdata),
        .s_tkeep   (s_tkeep),
        .s_tlast   (s_tlast),
        .s_tvalid  (s_tvalid),
        .s_tready  (s_tready),
        .m_awaddr  (m_awaddr),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_bresp   (m_bresp),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .busy      (eng_busy),
        .done_ev   (done_ev),
        .err_ev    (err_ev),
        .count     (final_cnt)
    );

endmodule

// File: rtl/s2m_dma_chk.sv
// Protocol and control checker for the stream-to-memory DMA, bound to
// the top module. Assumes the stream never presents an all-zero TKEEP
// on a last beat.
module s2m_dma_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    localparam int BYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [1:0]        reg_wr_sel,
    input logic [LEN_W-1:0]  reg_wr_len,
    input logic              s_tready,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [DATA_W-1:0] m_wdata,
    input logic [BYTES-1:0]  m_wstrb,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic              halted,
    input logic              busy
);

    logic [1:0] outst;
    logic       aw_hs, b_hs;

    assign aw_hs = m_awvalid && m_awready;
    assign b_hs  = m_bvalid && m_bready;

    // Count of issued addresses not yet answered
    always_ff @(posedge clk) begin
        if (!rst_n) outst <= '0;
        else        outst <= outst + {1'b0, aw_hs} - {1'b0, b_hs};
    end

    // R2
    halted_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !s_tready);

    // R3
    arm_from_len_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_wr_en && reg_wr_sel == 2'd3 && reg_wr_len != '0));

    // R4
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R4
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));

    // R5
    strb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_wvalid |-> (m_wstrb != '0));

    // R11
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aw_hs |-> (outst == 2'd0));

    // R11
    outst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= 2'd1);

endmodule

bind s2m_dma s2m_dma_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wr_sel (reg_wr_sel),
    .reg_wr_len (reg_wr_data[LEN_W-1:0]),
    .s_tready   (s_tready),
    .m_awaddr   (m_awaddr),
    .m_awvalid  (m_awvalid),
    .m_awready  (m_awready),
    .m_wdata    (m_wdata),
    .m_wstrb    (m_wstrb),
    .m_wvalid   (m_wvalid),
    .m_wready   (m_wready),
    .m_bvalid   (m_bvalid),
    .m_bready   (m_bready),
    .halted     (sts_halted),
    .busy       (eng_busy)
);

// File: tb/s2m_dma_bench.sv
`timescale 1ns/1ps
module s2m_dma_bench;

    localparam int DW = 32;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int NB = DW / 8;
    localparam int MEMSZ = 1024;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr_en;
    logic [1:0]    reg_wr_sel, reg_rd_sel;
    logic [31:0]   reg_wr_data, reg_rd_data;
    logic          irq;
    logic [DW-1:0] s_tdata;
    logic [NB-1:0] s_tkeep;
    logic          s_tlast, s_tvalid, s_tready;
    logic [AW-1:0] m_awaddr;
    logic [7:0]    m_awlen;
    logic [2:0]    m_awsize;
    logic [1:0]    m_awburst;
    logic          m_awvalid, m_awready;
    logic [DW-1:0] m_wdata;
    logic [NB-1:0] m_wstrb;
    logic          m_wlast, m_wvalid, m_wready;
    logic [1:0]    m_bresp;
    logic          m_bvalid, m_bready;

    always #2 clk = ~clk;

    s2m_dma u_s2m_dma (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data), .irq(irq),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mem [0:MEMSZ-1];
    logic [7:0] pk [0:255];
    bit   inject_err = 1'b0;
    bit   aw_got, w_got;
    logic [AW-1:0] aw_a;
    logic [DW-1:0] w_d;
    logic [NB-1:0] w_s;
    int   outst = 0;
    int   max_outst = 0;
    bit   bad_attr = 1'b0;

    // Memory-side model: random readies, one write per address/data pair
    always @(negedge clk) begin
        m_awready = ($urandom % 3) != 0;
        m_wready  = ($urandom % 3) != 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            aw_got   <= 1'b0;
            w_got    <= 1'b0;
            m_bvalid <= 1'b0;
            m_bresp  <= 2'b00;
        end else begin
            if (m_awvalid && m_awready) begin
                aw_got <= 1'b1;
                aw_a   <= m_awaddr;
                outst   = outst + 1;
                if (outst > max_outst) max_outst = outst;
                if (m_awlen != 8'd0 || m_awsize != 3'd2 || m_awburst != 2'b01) bad_attr = 1'b1;
            end
            if (m_wvalid && m_wready) begin
                w_got <= 1'b1;
                w_d   <= m_wdata;
                w_s   <= m_wstrb;
            end
            if (aw_got && w_got && !m_bvalid) begin
                for (int i = 0; i < NB; i++) begin
                    if (w_s[i]) mem[(int'(aw_a) + i) % MEMSZ] = w_d[8*i +: 8];
                end
                m_bvalid <= 1'b1;
                m_bresp  <= inject_err ? 2'b10 : 2'b00;
                aw_got   <= 1'b0;
                w_got    <= 1'b0;
            end
            if (m_bvalid && m_bready) begin
                m_bvalid <= 1'b0;
                outst     = outst - 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 d = reg_rd_data;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hEE;
    endtask

    // Expected last-beat TKEEP for a packet of n bytes
    function automatic logic [NB-1:0] last_keep(input int n);
        int rem = n - ((n - 1) / NB) * NB;
        return NB'((1 << rem) - 1);
    endfunction

    task automatic send_packet(input int n);
        int beats = (n + NB - 1) / NB;
        for (int i = 0; i < n; i++) pk[i] = 8'($urandom);
        for (int b = 0; b < beats; b++) begin
            bit hs = 1'b0;
            int tries = 0;
            while (!hs && tries < 3000) begin
                @(negedge clk);
                s_tvalid = ($urandom % 4) != 0;
                s_tlast  = (b == beats - 1);
                s_tkeep  = s_tlast ? last_keep(n) : '1;
                for (int k = 0; k < NB; k++)
                    s_tdata[8*k +: 8] = (b*NB + k < n) ? pk[b*NB + k] : 8'h00;
                #1 hs = s_tvalid && s_tready;
                tries++;
            end
            if (!hs) check("stream stall", 32'd0, 32'd1);
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        int t = 0;
        do begin
            rd_reg(2'd1, st);
            t++;
        end while (!st[1] && t < 3000);
        if (!st[1]) check("idle timeout", 32'd0, 32'd1);
    endtask

    // Count mismatches of the first n bytes at dst; count non-EE bytes after
    function automatic int mem_mismatch(input int dst, input int n);
        int e = 0;
        for (int i = 0; i < n; i++) if (mem[dst + i] !== pk[i]) e++;
        return e;
    endfunction

    function automatic int tail_dirty(input int from, input int upto);
        int e = 0;
        for (int i = from; i < upto; i++) if (mem[i] !== 8'hEE) e++;
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cap, n, dst, die, eie;
        void'($urandom(32'd2024));
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
        reg_rd_sel = '0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tkeep = '0; s_tdata = '0;
        fill_mem();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, v); check("R1 ctrl", v, 32'h0);
        rd_reg(2'd1, v); check("R1 status", v, 32'h3);
        rd_reg(2'd3, v); check("R1 length", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 tready", 32'(s_tready), 32'h0);

        // R3 length write while halted is ignored
        wr_reg(2'd3, 32'd16);
        rd_reg(2'd3, v); check("R3 halted len write", v, 32'h0);
        check("R3 halted tready", 32'(s_tready), 32'h0);

        // R2 run clears halted, not yet ready
        wr_reg(2'd0, 32'h1);
        rd_reg(2'd1, v); check("R2 status after run", v, 32'h2);
        repeat (3) @(negedge clk);
        check("R2 tready before arm", 32'(s_tready), 32'h0);

        // R3 zero length has no effect
        wr_reg(2'd3, 32'd0);
        repeat (2) @(negedge clk);
        rd_reg(2'd1, v); check("R3 zero len status", v, 32'h2);
        check("R3 zero len tready", 32'(s_tready), 32'h0);

        // R4 R5 R6 R7 R10 random packets that fit
        for (int t = 0; t < 24; t++) begin
            cap = 1 + int'($urandom % 120);
            n   = (t % 4 == 0) ? cap : 1 + int'($urandom % cap);
            dst = int'($urandom % 200) * 4;
            die = int'($urandom % 2);
            eie = int'($urandom % 2);
            fill_mem();
            wr_reg(2'd0, 32'(1 | (die << 1) | (eie << 2)));
            wr_reg(2'd2, 32'(dst));
            wr_reg(2'd3, 32'(cap));
            send_packet(n);
            wait_idle();
            check($sformatf("R4 data t%0d", t), 32'(mem_mismatch(dst, n)), 32'h0);
            check($sformatf("R5 tail t%0d", t), 32'(tail_dirty(dst + n, dst + n + 8)), 32'h0);
            rd_reg(2'd3, v); check($sformatf("R6 length t%0d", t), v, 32'(n));
            rd_reg(2'd1, v); check($sformatf("R6 status t%0d", t), v, 32'h6);
            check($sformatf("R7 irq t%0d", t), 32'(irq), 32'(die));
            wr_reg(2'd1, 32'h4);
            rd_reg(2'd1, v); check($sformatf("R10 clear t%0d", t), v, 32'h2);
        end
        check("R11 outstanding", 32'(max_outst), 32'd1);
        check("R4 burst attributes", 32'(bad_attr), 32'd0);

        // R10 writing zero does not clear
        wr_reg(2'd0, 32'h3);
        wr_reg(2'd2, 32'd0);
        wr_reg(2'd3, 32'd4);
        fill_mem();
        send_packet(4);
        wait_idle();
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, v); check("R10 write zero keeps flag", v, 32'h6);
        check("R7 irq done", 32'(irq), 32'h1);
        wr_reg(2'd1, 32'h4);

        // R8 overflow ending inside a beat
        fill_mem();
        wr_reg(2'd0, 32'h5);
        wr_reg(2'd2, 32'd64);
        wr_reg(2'd3, 32'd10);
        send_packet(23);
        wait_idle();
        check("R8 data kept", 32'(mem_mismatch(64, 10)), 32'h0);
        check("R8 nothing past buffer", 32'(tail_dirty(74, 100)), 32'h0);
        rd_reg(2'd1, v); check("R8 status", v, 32'hB);
        rd_reg(2'd0, v); check("R8 run cleared", v, 32'h4);
        rd_reg(2'd3, v); check("R8 length", v, 32'd10);
        check("R7 irq error", 32'(irq), 32'h1);
        check("R8 tready after halt", 32'(s_tready), 32'h0);
        wr_reg(2'd1, 32'h8);
        rd_reg(2'd1, v); check("R10 error clear", v, 32'h3);
        check("R10 irq low", 32'(irq), 32'h0);

        // R8 overflow at a beat boundary
        fill_mem();
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd2, 32'd200);
        wr_reg(2'd3, 32'd8);
        send_packet(13);
        wait_idle();
        check("R8 boundary data", 32'(mem_mismatch(200, 8)), 32'h0);
        check("R8 boundary past", 32'(tail_dirty(208, 224)), 32'h0);
        rd_reg(2'd1, v); check("R8 boundary status", v, 32'hB);
        rd_reg(2'd3, v); check("R8 boundary length", v, 32'd8);
        check("R7 no irq when disabled", 32'(irq), 32'h0);
        wr_reg(2'd1, 32'h8);

        // R9 write response error
        fill_mem();
        inject_err = 1'b1;
        wr_reg(2'd0, 32'h1);
        wr_reg(2'd2, 32'd400);
        wr_reg(2'd3, 32'd40);
        send_packet(20);
        wait_idle();
        inject_err = 1'b0;
        rd_reg(2'd1, v); check("R9 status", v, 32'hB);
        check("R9 later beats not written", 32'(tail_dirty(404, 440)), 32'h0);
        check("R9 tready after halt", 32'(s_tready), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule